// File: doc/BRIEF.md
# Camera register bus master

This block is a two-wire serial master that programs and reads back the 8-bit configuration registers of an image sensor. A host hands it one command at a time: a request strobe, a read/write select, an 8-bit register index and, for writes, an 8-bit value. The block turns the command into bus frames, drives the clock line open-drain through an output-enable and the data line through its own output-enable, samples the data line through an input, and reports the outcome with a one-cycle completion pulse, a read-data byte and an acknowledge-error flag.

A register write is one frame: start condition, write address byte, register index, value, stop condition, with a ninth-bit acknowledge from the sensor after every byte. A register read is two frames. The first is an index-only write frame that sets the sensor's register pointer. The second is a short frame that carries the read address byte and then one byte driven by the sensor. The master answers that byte with a not-acknowledge and closes with a stop. There is no repeated start. When the sensor leaves any acknowledge slot high, the block sends a stop at once and ends the command with the error flag set.

The bus rate comes from an integer divider of the system clock. Every bit period is split into four equal phases of `QTR_CYCLES` clock cycles each.

Top module: `cam_regbus_master`

## Requirements
- R1: Each byte goes on the bus most significant bit first, for bytes the master sends and for the byte it receives. Data is stable while the clock line is released, and the master samples the data line in the middle of the released clock phase.
- R2: A write command produces a single frame: start, address byte 0xC0 (device address 0x60 with bit 0 = 0 for write), register index, value, stop. The sensor may acknowledge after each of the three bytes, and there is no stop or start between them.
- R3: A read command produces an index-only frame (start, 0xC0, register index, stop) and then a frame with start, 0xC1 (bit 0 = 1 for read), one byte from the sensor, a master not-acknowledge (data line released in the ninth slot) and stop. The received byte appears on `rsp_rdata` together with `rsp_done`.
- R4: During a byte, successive rising edges of the clock line are exactly 4 x `QTR_CYCLES` system clock cycles apart, and never closer.
- R5: The data line changes while the clock line is released only in two cases: a start (data line falls) or a stop (data line rises). A write command makes one start condition and a read command makes two.
- R6: If any address, index or value byte is not acknowledged (data line high in the ninth slot), the master stops at once, sends no further bytes, and ends the command with `rsp_ack_err` = 1.
- R7: `rsp_done` is high for exactly one cycle per accepted command. `rsp_ack_err` holds its value from that pulse until the next command is accepted, and a command that completes cleanly reports 0.
- R8: A command is accepted only when `req_valid` is high and `busy` is low. `busy` rises the cycle after acceptance, and requests made while it is high are ignored.
- R9: After reset and whenever `busy` is low, both output-enables are low, so the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Command strobe, taken when busy is low |
| req_rd | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 8 | Sensor register index |
| req_wdata | input | 8 | Value for a write command |
| busy | output | 1 | Command in progress, new requests ignored |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read command |
| rsp_ack_err | output | 1 | A byte of the last command was not acknowledged |
| scl_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_in | input | 1 | Sampled level of the data line |

## Verification
The cases hardest to reach from the ports are a missing acknowledge on the second or third byte of a frame, and, for reads, on the index byte of the pointer frame. The abort must then end the first frame without a second start. The bench's sensor model has an injection knob that withholds the acknowledge at a chosen byte position. Directed commands hit each position, and about one random command in six carries an injected fault. The model counts received bytes and start conditions, so a master that sends a byte after a failure, or opens the read frame anyway, shows up in the counts. Requests pulsed during a running command, and the values 0x01 and 0x80, cover the ignore rule and the bit order.

// File: rtl/cam_regbus_pkg.sv
package cam_regbus_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_WBYTE = 3'd2,
    OP_RBYTE = 3'd3,
    OP_STOP  = 3'd4
  } bus_op_e;

  typedef struct packed {
    bus_op_e    op;
    logic [7:0] data;
    logic       chk_ack;
    logic       last;
  } step_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/cam_regbus_qtick.sv
module cam_regbus_qtick #(
  parameter int QTR_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QTR_CYCLES > 2) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cam_regbus_bitengine.sv
module cam_regbus_bitengine
  import cam_regbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       op_start,
  input  bus_op_e    op_in,
  input  logic [7:0] data_in,
  input  logic       sda_in,
  output logic       run,
  output logic       op_done,
  output logic       ack_n,
  output logic [7:0] rx_byte,
  output logic       scl_oe,
  output logic       sda_oe
);
  bus_op_e    op_q, op_d;
  logic [1:0] qtr_q, qtr_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       samp_q, samp_d;
  logic       ackn_q, ackn_d;
  logic       done_q, done_d;
  logic       scl_q, sda_q;
  logic       scl_lo, sda_lo, is_byte;

  assign is_byte = (op_q == OP_WBYTE) || (op_q == OP_RBYTE);
  assign run     = (op_q != OP_NONE);
  assign op_done = done_q;
  assign ack_n   = ackn_q;
  assign rx_byte = sh_q;
  assign scl_oe  = scl_q;
  assign sda_oe  = sda_q;

  // line levels for the current quarter of the current bit
  always_comb begin
    scl_lo = scl_q;
    sda_lo = sda_q;
    unique case (op_q)
      OP_START: begin
        sda_lo = (qtr_q >= 2'd2);
        scl_lo = (qtr_q == 2'd3);
      end
      OP_STOP: begin
        sda_lo = (qtr_q <= 2'd1);
        scl_lo = (qtr_q == 2'd0);
      end
      OP_WBYTE: begin
        scl_lo = (qtr_q == 2'd0) || (qtr_q == 2'd3);
        sda_lo = (bit_q != 4'd8) && !sh_q[7];
      end
      OP_RBYTE: begin
        scl_lo = (qtr_q == 2'd0) || (qtr_q == 2'd3);
        sda_lo = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    op_d   = op_q;
    qtr_d  = qtr_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    samp_d = samp_q;
    ackn_d = ackn_q;
    done_d = 1'b0;
    if (op_q == OP_NONE) begin
      if (op_start) begin
        op_d  = op_in;
        qtr_d = 2'd0;
        bit_d = 4'd0;
        sh_d  = data_in;
      end
    end else if (tick) begin
      qtr_d = qtr_q + 2'd1;
      if (qtr_q == 2'd1) begin
        samp_d = sda_in;
        if (bit_q == 4'd8) ackn_d = sda_in;
      end
      if (qtr_q == 2'd3) begin
        if (is_byte && (bit_q != 4'd8)) sh_d = {sh_q[6:0], samp_q};
        if (!is_byte || (bit_q == 4'd8)) begin
          op_d   = OP_NONE;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      qtr_q  <= 2'd0;
      bit_q  <= 4'd0;
      sh_q   <= 8'd0;
      samp_q <= 1'b1;
      ackn_q <= 1'b0;
      done_q <= 1'b0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
    end else begin
      op_q   <= op_d;
      qtr_q  <= qtr_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      samp_q <= samp_d;
      ackn_q <= ackn_d;
      done_q <= done_d;
      if (run) begin
        scl_q <= scl_lo;
        sda_q <= sda_lo;
      end
    end
  end

  // R5: data moves under a released clock only inside start or stop
  a_r5_sda_edge_only_in_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_q && !$stable(sda_q)) |-> ($past(op_q) == OP_START || $past(op_q) == OP_STOP));

  // R1: while a byte is in flight and the clock is released, data is stable
  a_r1_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(is_byte) && !scl_q && !$past(scl_q)) |-> $stable(sda_q));

endmodule

// File: rtl/cam_regbus_sequencer.sv
module cam_regbus_sequencer
  import cam_regbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_rd,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic       eng_done,
  input  logic       eng_ackn,
  input  logic [7:0] eng_rx,
  output logic       op_start,
  output bus_op_e    op_out,
  output logic [7:0] data_out,
  output logic       busy,
  output logic [7:0] rdata,
  output logic       done,
  output logic       ack_err
);
  localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_BYTE = {DEV_ADDR, 1'b1};

  seq_state_e st_q, st_d;
  logic [2:0] step_q, step_d;
  logic       rd_q, rd_d, abort_q, abort_d;
  logic [7:0] addr_q, addr_d, wdat_q, wdat_d, rdata_q, rdata_d;
  logic       err_q, err_d, done_q, done_d;
  step_t      cur;

  function automatic step_t step_of(input logic rd, input logic [2:0] idx,
                                    input logic [7:0] ra, input logic [7:0] wd,
                                    input logic ab);
    step_t s;
    s.op = OP_STOP; s.data = 8'hFF; s.chk_ack = 1'b0; s.last = 1'b1;
    if (!ab) begin
      if (!rd) begin
        unique case (idx)
          3'd0: begin s.op = OP_START; s.last = 1'b0; end
          3'd1: begin s.op = OP_WBYTE; s.data = WR_BYTE; s.chk_ack = 1'b1; s.last = 1'b0; end
          3'd2: begin s.op = OP_WBYTE; s.data = ra;      s.chk_ack = 1'b1; s.last = 1'b0; end
          3'd3: begin s.op = OP_WBYTE; s.data = wd;      s.chk_ack = 1'b1; s.last = 1'b0; end
          default: ;
        endcase
      end else begin
        unique case (idx)
          3'd0: begin s.op = OP_START; s.last = 1'b0; end
          3'd1: begin s.op = OP_WBYTE; s.data = WR_BYTE; s.chk_ack = 1'b1; s.last = 1'b0; end
          3'd2: begin s.op = OP_WBYTE; s.data = ra;      s.chk_ack = 1'b1; s.last = 1'b0; end
          3'd3: begin s.op = OP_STOP;  s.last = 1'b0; end
          3'd4: begin s.op = OP_START; s.last = 1'b0; end
          3'd5: begin s.op = OP_WBYTE; s.data = RD_BYTE; s.chk_ack = 1'b1; s.last = 1'b0; end
          3'd6: begin s.op = OP_RBYTE; s.last = 1'b0; end
          default: ;
        endcase
      end
    end
    return s;
  endfunction

  assign cur      = step_of(rd_q, step_q, addr_q, wdat_q, abort_q);
  assign op_start = (st_q == SQ_ISSUE);
  assign op_out   = cur.op;
  assign data_out = cur.data;
  assign busy     = (st_q != SQ_IDLE);
  assign rdata    = rdata_q;
  assign done     = done_q;
  assign ack_err  = err_q;

  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    rd_d    = rd_q;
    abort_d = abort_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    rdata_d = rdata_q;
    err_d   = err_q;
    done_d  = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (req_valid) begin
        rd_d    = req_rd;
        addr_d  = req_addr;
        wdat_d  = req_wdata;
        step_d  = 3'd0;
        abort_d = 1'b0;
        err_d   = 1'b0;
        st_d    = SQ_ISSUE;
      end
      SQ_ISSUE: st_d = SQ_WAIT;
      SQ_WAIT: if (eng_done) begin
        if (cur.op == OP_RBYTE) rdata_d = eng_rx;
        if (cur.chk_ack && eng_ackn) begin
          err_d   = 1'b1;
          abort_d = 1'b1;
          st_d    = SQ_ISSUE;
        end else if (cur.last) begin
          done_d = 1'b1;
          st_d   = SQ_IDLE;
        end else begin
          step_d = step_q + 3'd1;
          st_d   = SQ_ISSUE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      step_q  <= 3'd0;
      rd_q    <= 1'b0;
      abort_q <= 1'b0;
      addr_q  <= 8'd0;
      wdat_q  <= 8'd0;
      rdata_q <= 8'd0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      step_q  <= step_d;
      rd_q    <= rd_d;
      abort_q <= abort_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: error flag holds while no command is accepted
  a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE && !req_valid) |=> $stable(err_q));

  // R8: the latched command is not disturbed while busy
  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SQ_IDLE) |=> ($stable(addr_q) && $stable(rd_q) && $stable(wdat_q)));

  // R6: a missing acknowledge is followed by a stop, nothing else
  a_r6_abort_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WAIT && eng_done && cur.chk_ack && eng_ackn) |=> (op_start && op_out == OP_STOP));

endmodule

// File: rtl/cam_regbus_master.sv
module cam_regbus_master
  import cam_regbus_pkg::*;
#(
  parameter int         QTR_CYCLES = 4,
  parameter logic [6:0] DEV_ADDR   = 7'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_rd,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       busy,
  output logic       rsp_done,
  output logic [7:0] rsp_rdata,
  output logic       rsp_ack_err,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic [1:0] rsync_q;
  logic       rst_core_n;
  logic       tick, eng_run, eng_done, eng_ackn, op_start;
  logic [7:0] eng_rx, op_data;
  bus_op_e    op_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  cam_regbus_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_qtick (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (eng_run),
    .tick  (tick)
  );

  cam_regbus_bitengine u_eng (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick     (tick),
    .op_start (op_start),
    .op_in    (op_sel),
    .data_in  (op_data),
    .sda_in   (sda_in),
    .run      (eng_run),
    .op_done  (eng_done),
    .ack_n    (eng_ackn),
    .rx_byte  (eng_rx),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe)
  );

  cam_regbus_sequencer #(.DEV_ADDR(DEV_ADDR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .eng_done  (eng_done),
    .eng_ackn  (eng_ackn),
    .eng_rx    (eng_rx),
    .op_start  (op_start),
    .op_out    (op_sel),
    .data_out  (op_data),
    .busy      (busy),
    .rdata     (rsp_rdata),
    .done      (rsp_done),
    .ack_err   (rsp_ack_err)
  );

  // R9: the bus is released whenever no command runs
  a_r9_bus_released: assert property (@(posedge clk) disable iff (!rst_core_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R8: a request taken while idle raises busy on the next cycle
  a_r8_busy_follows_req: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!busy && req_valid) |=> busy);

endmodule

// File: tb/sim_cam_regbus_master.sv
`timescale 1ns/1ps
module sim_cam_regbus_master;
  localparam int QTR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rd = 1'b0;
  logic [7:0] req_addr = 8'd0, req_wdata = 8'd0;
  logic busy, rsp_done, rsp_ack_err, scl_oe, sda_oe;
  logic [7:0] rsp_rdata;
  logic s_drv = 1'b0;
  logic scl_w, sda_w;

  always #2.5 clk = ~clk;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | s_drv);

  cam_regbus_master #(.QTR_CYCLES(QTR), .DEV_ADDR(7'h60)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_ack_err(rsp_ack_err),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- sensor model ----------------
  logic [7:0] smem [256];
  logic [7:0] sptr = 8'd0;
  logic [7:0] sh = 8'd0, txb = 8'd0;
  logic       rw = 1'b0, scl_p = 1'b1, sda_p = 1'b1, m_ack = 1'b0;
  int ph = 0, bcnt = 0, bidx = 0, nack_at = -1;
  int n_start = 0, n_rx = 0;

  always @(scl_w or sda_w) begin
    if (scl_w && scl_p && sda_p && !sda_w) begin
      n_start++; ph = 1; bcnt = 0; bidx = 0; s_drv = 1'b0;
    end else if (scl_w && scl_p && !sda_p && sda_w) begin
      ph = 0; s_drv = 1'b0;
    end else if (scl_w && !scl_p) begin
      if (ph == 1) begin sh = {sh[6:0], sda_w}; bcnt++; end
      else if (ph == 3) bcnt++;
      else if (ph == 4) m_ack = sda_w;
    end else if (!scl_w && scl_p) begin
      case (ph)
        1: if (bcnt == 8) begin
             logic ack;
             n_rx++;
             ack = 1'b1;
             if (bidx == 0) begin ack = (sh[7:1] == 7'h60); rw = sh[0]; end
             if (bidx == nack_at) ack = 1'b0;
             if (ack && bidx == 1) sptr = sh;
             if (ack && bidx == 2) smem[sptr] = sh;
             s_drv = ack;
             ph = ack ? 2 : 5;
           end
        2: begin
             s_drv = 1'b0; bcnt = 0; bidx++;
             if (rw) begin txb = smem[sptr]; s_drv = ~txb[7]; ph = 3; end
             else ph = 1;
           end
        3: if (bcnt == 8) begin s_drv = 1'b0; ph = 4; end
           else s_drv = ~txb[7-bcnt];
        4: ph = 5;
        default: ;
      endcase
    end
    scl_p = scl_w;
    sda_p = sda_w;
  end

  // ---------------- clock-line period monitor ----------------
  int gap = 0, min_gap = 1000000;
  logic scl_pc = 1'b1;
  always @(posedge clk) begin
    gap++;
    if (scl_w && !scl_pc) begin
      if (gap < min_gap) min_gap = gap;
      gap = 0;
    end
    scl_pc = scl_w;
  end

  // ---------------- reference model ----------------
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr = 8'd0;

  function automatic logic exp_err(input logic rd, input int nk);
    if (rd) return (nk == 0 || nk == 1);
    return (nk >= 0 && nk <= 2);
  endfunction

  function automatic int exp_rx(input logic rd, input int nk);
    if (exp_err(rd, nk)) return nk + 1;
    return 3;
  endfunction

  function automatic int exp_starts(input logic rd, input int nk);
    if (rd && !exp_err(rd, nk)) return 2;
    return 1;
  endfunction

  // ---------------- command driver ----------------
  logic [7:0] got_rd;
  logic       got_err;

  task automatic run_cmd(input logic rd, input logic [7:0] a, input logic [7:0] d,
                         input int nk, input logic poke_busy);
    int cyc, st0, rx0;
    logic [7:0] expd;
    logic ee;
    nack_at = nk;
    st0 = n_start; rx0 = n_rx;
    @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 busy after accept", busy == 1'b1, busy, 1);
    cyc = 0;
    while (!rsp_done && cyc < 5000) begin
      if (poke_busy && (cyc % 37 == 5)) begin
        req_valid = 1'b1; req_rd = ~rd; req_addr = a ^ 8'h5A; req_wdata = ~d;
      end else req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    got_rd = rsp_rdata; got_err = rsp_ack_err;
    chk("R7 done seen", rsp_done == 1'b1, rsp_done, 1);
    ee = exp_err(rd, nk);
    chk(rd ? "R6/R3 read ack_err" : "R6/R2 write ack_err", got_err == ee, got_err, ee);
    if (!rd) begin
      if (!ee || nk == 2) ref_ptr = a;
      if (!ee) ref_mem[a] = d;
    end else if (!ee) begin
      ref_ptr = a;
      expd = ref_mem[a];
      chk("R3 read data", got_rd == expd, got_rd, expd);
    end
    chk("R6 bytes on bus", (n_rx - rx0) == exp_rx(rd, nk), n_rx - rx0, exp_rx(rd, nk));
    chk("R5 start count", (n_start - st0) == exp_starts(rd, nk), n_start - st0, exp_starts(rd, nk));
    @(negedge clk);
    chk("R7 done one cycle", rsp_done == 1'b0, rsp_done, 0);
    chk("R9 bus released", (scl_oe | sda_oe | busy) == 1'b0, {busy, scl_oe, sda_oe}, 0);
    nack_at = -1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    for (int i = 0; i < 256; i++) begin
      smem[i] = 8'((i * 37 + 5) & 255);
      ref_mem[i] = 8'((i * 37 + 5) & 255);
    end
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 reset busy", busy == 1'b0, busy, 0);
    chk("R9 reset lines", (scl_oe | sda_oe) == 1'b0, {scl_oe, sda_oe}, 0);
    chk("R7 reset done/err", (rsp_done | rsp_ack_err) == 1'b0, {rsp_done, rsp_ack_err}, 0);

    // R1: bit order with single-bit patterns at both ends of the byte
    run_cmd(1'b0, 8'h12, 8'h01, -1, 1'b0);
    chk("R1 lsb-only value stored", smem[8'h12] == 8'h01, smem[8'h12], 8'h01);
    run_cmd(1'b0, 8'h13, 8'h80, -1, 1'b0);
    chk("R1 msb-only value stored", smem[8'h13] == 8'h80, smem[8'h13], 8'h80);
    run_cmd(1'b1, 8'h13, 8'h00, -1, 1'b0);
    chk("R1 msb-only read back", got_rd == 8'h80, got_rd, 8'h80);
    run_cmd(1'b1, 8'h12, 8'h00, -1, 1'b0);
    chk("R1 lsb-only read back", got_rd == 8'h01, got_rd, 8'h01);
    chk("R3 master nack after read byte", m_ack == 1'b1, m_ack, 1);
    chk("R4 bit period", min_gap == 4 * QTR, min_gap, 4 * QTR);

    // R6: a missing acknowledge at each byte position of a write
    for (int k = 0; k < 3; k++) begin
      run_cmd(1'b0, 8'h40 + 8'(k), 8'hA5, k, 1'b0);
      chk("R6 register untouched", smem[8'h40 + 8'(k)] == ref_mem[8'h40 + 8'(k)],
          smem[8'h40 + 8'(k)], ref_mem[8'h40 + 8'(k)]);
    end
    repeat (20) @(negedge clk);
    chk("R7 ack_err held while idle", rsp_ack_err == 1'b1, rsp_ack_err, 1);
    // R6: read with a missing acknowledge on the pointer frame
    run_cmd(1'b1, 8'h44, 8'h00, 1, 1'b0);
    run_cmd(1'b1, 8'h45, 8'h00, 0, 1'b0);
    run_cmd(1'b1, 8'h46, 8'h00, -1, 1'b0);
    chk("R7 ack_err cleared by clean command", got_err == 1'b0, got_err, 0);

    // R8: requests during a running command are ignored
    run_cmd(1'b0, 8'h20, 8'h3C, -1, 1'b1);
    chk("R8 ignored target untouched", smem[8'h20 ^ 8'h5A] == ref_mem[8'h20 ^ 8'h5A],
        smem[8'h20 ^ 8'h5A], ref_mem[8'h20 ^ 8'h5A]);
    chk("R2 value written", smem[8'h20] == 8'h3C, smem[8'h20], 8'h3C);
    run_cmd(1'b1, 8'h21, 8'h00, -1, 1'b1);

    // random mix
    for (int it = 0; it < 45; it++) begin
      logic r;
      logic [7:0] a, d;
      int nk;
      r  = 1'($urandom % 2);
      a  = 8'($urandom % 32);
      d  = 8'($urandom);
      nk = ($urandom % 6 == 0) ? int'($urandom % 3) : -1;
      run_cmd(r, a, d, nk, 1'b0);
      if (!r && !exp_err(r, nk))
        chk("R2 random write stored", smem[a] == d, smem[a], d);
    end
    chk("R4 bit period after random", min_gap == 4 * QTR, min_gap, 4 * QTR);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule